// File: doc/BRIEF.md
# Reciprocal frequency meter

This block measures the frequency of an asynchronous input signal against a local reference clock. It runs two counters over the same window. One counts rising edges of the input and the other counts reference clock cycles. Both ends of the window fall on input edges. After an arm command the block waits for an input edge to open the window. It keeps the window open until at least a minimum number of reference cycles has passed, then closes it on the next input edge. Because the window spans a whole number of input periods, the input count is exact. The reference count gives the window length, with an error of only a couple of reference periods.

The input is first brought into the reference domain by a synchronizer, and then its rising edges are detected. The input rate must therefore stay below half the reference rate. When the window closes, both counts freeze and a done flag is raised. The flag and counts hold until the next arm command, which clears them. Software divides the edge count by the tick count to obtain the frequency. If the input never toggles after arming, a programmable timeout reports a no-signal status. A sticky flag reports that either counter wrapped.

Top module: `recip_freq_meter`

## Requirements
- R1: After reset, `cycle_count` and `ref_count` are zero, and `done`, `no_signal` and `overflow` are low.
- R2: A cycle with `arm` high clears both counts and the `done`, `no_signal` and `overflow` flags. This holds in every state, and the cleared values appear on the next clock.
- R3: After arming and before the first rising edge of `sig_in` is detected, both counts stay zero.
- R4: With a periodic input of P reference cycles per period and a minimum gate of G, the final values are `cycle_count` = ceil(G/P) and `ref_count` = `cycle_count` × P. `cycle_count` counts the rising edges after the opening edge, up to and including the closing edge. `ref_count` counts the reference cycles from the opening edge to the closing edge.
- R5: The window closes on the first detected rising input edge at which the reference count has reached at least G. When no counter has wrapped, the final values satisfy G ≤ `ref_count` < G + P.
- R6: Once `done` is high, it stays high and both counts stay unchanged until `arm` is asserted, even while the input keeps toggling.
- R7: If no rising input edge is detected within `timeout_ticks` reference cycles after arming, `no_signal` goes high and the counts remain zero. A `timeout_ticks` value of 0 disables the timeout.
- R8: `overflow` goes high when either counter wraps from all ones to zero, and it stays high until the next arm. It stays low for measurements that do not wrap.
- R9: Only rising edges are counted. An input held at a constant level after the window opens never increases `cycle_count`, and `done` stays low.
- R10: `done` and `no_signal` are never high at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| sig_in | input | 1 | Unknown input signal, asynchronous |
| arm | input | 1 | Starts a new measurement and clears the previous result |
| timeout_ticks | input | TO_W | Reference cycles to wait for the first edge (0 = wait forever) |
| cycle_count | output | CNT_W | Input rising edges inside the window |
| ref_count | output | CNT_W | Reference cycles inside the window |
| done | output | 1 | Measurement complete, results frozen |
| no_signal | output | 1 | Timeout expired with no input edge |
| overflow | output | 1 | A counter wrapped during this measurement |

## Verification
The bench sweeps input periods that sit just below, at and just above divisors of the minimum gate, and includes a period longer than the whole gate. This exposes an off-by-one in the opening or closing edge: such an error shows up as a cycle count one high or low, or a tick count that is one period short or long. It holds the input high after the window opens, to catch a design that counts levels instead of edges. It also keeps toggling the input after completion, to catch a design whose results drift. The timeout is probed on both sides of its expiry and with the disable value. A narrow second instance forces the tick counter to wrap, which shows whether the overflow flag is missed or the gate decision is lost after the wrap.

// File: rtl/fm_pkg.sv
package fm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_WAIT  = 3'd1,
    ST_GATE  = 3'd2,
    ST_DONE  = 3'd3,
    ST_NOSIG = 3'd4
  } fm_state_e;
endpackage

// File: rtl/fm_edge_sync.sv
module fm_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_in,
  output logic rise_o
);
  localparam int DEPTH = STAGES + 1;

  logic [DEPTH-1:0] chain_q;

  // Stage 0 samples the asynchronous pin; later stages settle and keep history.
  always_ff @(posedge clk) begin
    if (!rst_n) chain_q[0] <= 1'b0;
    else        chain_q[0] <= sig_in;
  end

  for (genvar i = 1; i < DEPTH; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) chain_q[i] <= 1'b0;
      else        chain_q[i] <= chain_q[i-1];
    end
  end

  assign rise_o = chain_q[STAGES-1] & ~chain_q[STAGES];
endmodule

// File: rtl/fm_wrap_counter.sv
module fm_wrap_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  // Returns {carry, sum} of a single increment.
  function automatic logic [W:0] step(input logic [W-1:0] v);
    return {1'b0, v} + {{W{1'b0}}, 1'b1};
  endfunction

  logic [W:0] nxt;

  assign nxt  = step(cnt);
  assign wrap = inc & ~clr & nxt[W];

  always_ff @(posedge clk) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (inc) cnt <= nxt[W-1:0];
  end
endmodule

// File: rtl/recip_freq_meter.sv
module recip_freq_meter #(
  parameter int CNT_W    = 32,
  parameter int MIN_GATE = 5000000,
  parameter int TO_W     = 32,
  parameter int SYNC_STG = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sig_in,
  input  logic             arm,
  input  logic [TO_W-1:0]  timeout_ticks,
  output logic [CNT_W-1:0] cycle_count,
  output logic [CNT_W-1:0] ref_count,
  output logic             done,
  output logic             no_signal,
  output logic             overflow
);
  import fm_pkg::*;

  localparam logic [CNT_W-1:0] GATE_TICKS = CNT_W'(MIN_GATE);

  // True when the tick count after this cycle's increment meets the gate.
  function automatic logic gate_reached(input logic [CNT_W-1:0] ticks);
    return (ticks + CNT_W'(1)) == GATE_TICKS;
  endfunction

  // True when this waiting cycle is the last one allowed by the timeout.
  function automatic logic wait_expired(input logic [TO_W-1:0] waited,
                                        input logic [TO_W-1:0] limit);
    return (limit != '0) && (waited == limit - TO_W'(1));
  endfunction

  fm_state_e state_q, state_d;
  logic      edge_evt, waiting, gating;
  logic      start_evt, stop_evt, timeout_evt, wrap_evt;
  logic      gate_met_q, gate_now;
  logic      ref_wrap, cyc_wrap;
  logic [TO_W-1:0] wait_q;

  fm_edge_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst_n(rst_n), .sig_in(sig_in), .rise_o(edge_evt)
  );

  assign waiting     = (state_q == ST_WAIT);
  assign gating      = (state_q == ST_GATE);
  assign start_evt   = waiting & edge_evt & ~arm;
  assign gate_now    = gate_met_q | gate_reached(ref_count);
  assign stop_evt    = gating & edge_evt & gate_now & ~arm;
  assign timeout_evt = waiting & ~edge_evt & ~arm & wait_expired(wait_q, timeout_ticks);
  assign wrap_evt    = ref_wrap | cyc_wrap;

  fm_wrap_counter #(.W(CNT_W)) u_ref_cnt (
    .clk(clk), .rst_n(rst_n), .clr(arm | start_evt), .inc(gating),
    .cnt(ref_count), .wrap(ref_wrap)
  );

  fm_wrap_counter #(.W(CNT_W)) u_cyc_cnt (
    .clk(clk), .rst_n(rst_n), .clr(arm | start_evt), .inc(gating & edge_evt),
    .cnt(cycle_count), .wrap(cyc_wrap)
  );

  always_comb begin
    state_d = state_q;
    if (arm)              state_d = ST_WAIT;
    else if (start_evt)   state_d = ST_GATE;
    else if (timeout_evt) state_d = ST_NOSIG;
    else if (stop_evt)    state_d = ST_DONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      gate_met_q <= 1'b0;
      overflow   <= 1'b0;
      wait_q     <= '0;
    end else begin
      state_q <= state_d;
      if (arm | start_evt)         gate_met_q <= 1'b0;
      else if (gating & gate_now)  gate_met_q <= 1'b1;
      if (arm)           overflow <= 1'b0;
      else if (wrap_evt) overflow <= 1'b1;
      if (arm)          wait_q <= '0;
      else if (waiting) wait_q <= wait_q + TO_W'(1);
    end
  end

  assign done      = (state_q == ST_DONE);
  assign no_signal = (state_q == ST_NOSIG);
endmodule

// File: rtl/fm_checker.sv
module fm_checker #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             arm,
  input logic             edge_evt,
  input logic             waiting,
  input logic             done,
  input logic             no_signal,
  input logic             overflow,
  input logic [CNT_W-1:0] cycle_count,
  input logic [CNT_W-1:0] ref_count
);
  assert_arm_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> (cycle_count == '0 && ref_count == '0 && !done && !no_signal && !overflow));

  assert_wait_idle_counts_R3: assert property (@(posedge clk) disable iff (!rst_n)
    waiting |-> (cycle_count == '0 && ref_count == '0));

  assert_close_on_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(edge_evt));

  assert_result_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !arm) |=> (done && $stable(cycle_count) && $stable(ref_count)));

  assert_nosig_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    no_signal |-> (cycle_count == '0 && ref_count == '0));

  assert_nosig_no_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(no_signal) |-> !$past(edge_evt));

  assert_overflow_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !arm) |=> overflow);

  assert_flags_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && no_signal));
endmodule

bind recip_freq_meter fm_checker #(.CNT_W(CNT_W)) u_fm_chk (
  .clk(clk), .rst_n(rst_n), .arm(arm), .edge_evt(edge_evt), .waiting(waiting),
  .done(done), .no_signal(no_signal), .overflow(overflow),
  .cycle_count(cycle_count), .ref_count(ref_count)
);

// File: tb/recip_freq_meter_tb_top.sv
module recip_freq_meter_tb_top;
  localparam int G1 = 1000;
  localparam int G2 = 200;
  localparam int NV = 6;
  // {period, high cycles}
  localparam int VEC [NV][2] = '{'{2, 1}, '{3, 1}, '{7, 3}, '{50, 49}, '{1000, 500}, '{1001, 400}};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sig_in = 1'b0;
  logic arm1 = 1'b0, arm2 = 1'b0;
  logic [15:0] to1 = '0;
  logic [31:0] cyc1, ref1;
  logic [7:0]  cyc2, ref2;
  logic done1, nos1, ovf1, done2, nos2, ovf2;
  logic gen_en = 1'b0;
  int   gen_per = 2, gen_hi = 1, phase = 0;
  int   errors = 0, checks = 0;

  always #10 clk = ~clk;

  recip_freq_meter #(.CNT_W(32), .MIN_GATE(G1), .TO_W(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .sig_in(sig_in), .arm(arm1), .timeout_ticks(to1),
    .cycle_count(cyc1), .ref_count(ref1), .done(done1), .no_signal(nos1), .overflow(ovf1)
  );

  recip_freq_meter #(.CNT_W(8), .MIN_GATE(G2), .TO_W(16)) dut_ovf_i (
    .clk(clk), .rst_n(rst_n), .sig_in(sig_in), .arm(arm2), .timeout_ticks(16'd0),
    .cycle_count(cyc2), .ref_count(ref2), .done(done2), .no_signal(nos2), .overflow(ovf2)
  );

  always @(negedge clk) begin
    if (gen_en) begin
      sig_in <= (phase < gen_hi);
      phase  <= (phase + 1 == gen_per) ? 0 : phase + 1;
    end else begin
      sig_in <= 1'b0;
      phase  <= 0;
    end
  end

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic arm_pulse(input bit which);
    @(negedge clk);
    if (which) arm2 = 1'b1; else arm1 = 1'b1;
    @(negedge clk);
    arm1 = 1'b0;
    arm2 = 1'b0;
  endtask

  task automatic quiet();
    gen_en = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic wait_done(input bit which);
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if ((which ? done2 : done1) == 1'b1) break;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R4 watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int cyc_e, ref_e, saved_c, saved_r;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 cycle_count", cyc1, 0);
    chk("R1 ref_count", ref1, 0);
    chk("R1 done", done1, 0);
    chk("R1 no_signal", nos1, 0);
    chk("R1 overflow", ovf1, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // Vector table: R4, R5, R8 (no wrap)
    for (int v = 0; v < NV; v++) begin
      quiet();
      arm_pulse(1'b0);
      gen_per = VEC[v][0];
      gen_hi  = VEC[v][1];
      gen_en  = 1'b1;
      wait_done(1'b0);
      cyc_e = (G1 + gen_per - 1) / gen_per;
      ref_e = cyc_e * gen_per;
      chk("R4 done", done1, 1);
      chk("R4 cycle_count", cyc1, cyc_e);
      chk("R4 ref_count", ref1, ref_e);
      chk("R5 gate lower bound", (ref1 >= G1), 1);
      chk("R5 first edge after gate", (ref1 < G1 + gen_per), 1);
      chk("R8 no overflow", ovf1, 0);
    end

    // R6: results stay frozen while input keeps toggling
    saved_c = cyc1;
    saved_r = ref1;
    repeat (40) @(negedge clk);
    chk("R6 done held", done1, 1);
    chk("R6 cycle_count frozen", cyc1, saved_c);
    chk("R6 ref_count frozen", ref1, saved_r);

    // R2: arm clears the result
    quiet();
    arm_pulse(1'b0);
    chk("R2 cycle_count cleared", cyc1, 0);
    chk("R2 ref_count cleared", ref1, 0);
    chk("R2 done cleared", done1, 0);

    // R3: waiting without edges keeps counts at zero (timeout disabled)
    repeat (200) @(negedge clk);
    chk("R3 cycle_count idle", cyc1, 0);
    chk("R3 ref_count idle", ref1, 0);
    chk("R7 disabled timeout", nos1, 0);

    // R9: one rising edge, then held high: no count growth, no done
    @(negedge clk);
    sig_in = 1'b1;
    gen_en = 1'b0;
    force sig_in = 1'b1;
    repeat (2 * G1) @(negedge clk);
    chk("R9 cycle_count held level", cyc1, 0);
    chk("R9 done stays low", done1, 0);
    chk("R9 ticks run", (ref1 > G1), 1);
    release sig_in;
    quiet();

    // R7: timeout of 50 cycles
    to1 = 16'd50;
    arm_pulse(1'b0);
    repeat (38) @(negedge clk);
    chk("R7 before timeout", nos1, 0);
    repeat (20) @(negedge clk);
    chk("R7 after timeout", nos1, 1);
    chk("R7 counts zero", cyc1, 0);
    chk("R10 exclusive", done1 & nos1, 0);
    arm_pulse(1'b0);
    chk("R2 no_signal cleared", nos1, 0);
    to1 = 16'd0;

    // R8: tick counter wraps in the narrow instance
    quiet();
    arm_pulse(1'b1);
    gen_per = 150;
    gen_hi  = 75;
    gen_en  = 1'b1;
    wait_done(1'b1);
    chk("R8 done", done2, 1);
    chk("R8 cycle_count", cyc2, 2);
    chk("R8 wrapped ref_count", ref2, 300 % 256);
    chk("R8 overflow set", ovf2, 1);
    repeat (10) @(negedge clk);
    chk("R8 overflow sticky", ovf2, 1);
    quiet();
    arm_pulse(1'b1);
    chk("R2 overflow cleared", ovf2, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule